// File: doc/BRIEF.md
# Dual Tapped Shift Register with Parallel Segment Fill

This block holds two independent serial shift registers. Each one is a chain of 64 single-bit stages, split into four segments of 16 stages. A tap sits at the end of each segment, after stages 16, 32, 48 and 64. Stage 1 takes the serial input on every rising clock edge, so the serial input has no handshake. The register accepts one bit per cycle and never applies back-pressure. The valid/ready convention does not fit a chain that advances on every edge, so the serial pin is plain.

Each tap is a bidirectional pin, modelled as three signals: a stage value, an output-enable flag and an inbound value. When the fill-mode input is low, the taps are driven and the whole chain shifts as one 64-stage delay line. When fill mode is high, all tap drivers are released. The inbound values at the end of segments 1 to 3 then feed the first stage of the segment after each one. The four segments then load side by side, and a full 64-bit pattern goes in with 16 clocks. The last tap is never an input. Typical uses are delay lines, short-term serial storage and fast preload of long serial chains.

Both registers have their own clock, synchronous reset, serial input, fill-mode input and tap set. Neither one shares state with the other.

Top module: `tapsr_dual`

## Requirements
- R1: A high synchronous reset sampled at a rising edge clears all 64 stages of that channel, so every tap_q bit reads 0 after that edge.
- R2: Each rising edge loads the serial input into stage 1, whatever the fill-mode level. Stages change only at rising edges.
- R3: With fill mode low, each edge moves every stage n into stage n+1. Bit k of tap_q (k = 0..3) shows stage 16*(k+1), so a bit entered at stage 1 reaches tap_q[k] 16*(k+1) edges later.
- R4: Every bit of tap_oe equals the inverse of the fill-mode input, combinationally: the taps are released in the same cycle that fill mode goes high.
- R5: With fill mode high, an edge loads tap_d[j] (j = 0..2) into stage 16*(j+1)+1, which is stage 17, 33 or 49. All other stages shift as usual.
- R6: While fill mode is low, tap_d has no effect on any stage.
- R7: The stage-64 tap is never an input. Stages 50 to 64 keep shifting from their neighbour in both modes.
- R8: Sixteen edges with fill mode high, followed by fill mode low, give a fully determined 64-bit content. The fill bits come out in order at tap_q[3].
- R9: The two channels are independent: stimulus on one channel never changes the taps of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Channel A clock, rising edge active |
| rst_a | input | 1 | Channel A synchronous reset, active high |
| din_a | input | 1 | Channel A serial input into stage 1 |
| fill_a | input | 1 | Channel A fill mode (1 = taps are inputs) |
| tap_d_a | input | 3 | Channel A inbound tap values for stages 17, 33, 49 (bit 0 = stage 17) |
| tap_q_a | output | 4 | Channel A tap values, bit k = stage 16*(k+1) |
| tap_oe_a | output | 4 | Channel A tap drive enables |
| clk_b | input | 1 | Channel B clock, rising edge active |
| rst_b | input | 1 | Channel B synchronous reset, active high |
| din_b | input | 1 | Channel B serial input into stage 1 |
| fill_b | input | 1 | Channel B fill mode (1 = taps are inputs) |
| tap_d_b | input | 3 | Channel B inbound tap values for stages 17, 33, 49 (bit 0 = stage 17) |
| tap_q_b | output | 4 | Channel B tap values, bit k = stage 16*(k+1) |
| tap_oe_b | output | 4 | Channel B tap drive enables |

## Verification
The properties assume that reset is held high up to the first rising edge of each clock. They also assume that fill mode, the serial input and the inbound tap values settle before an edge and stay steady across it, so the value sampled at an edge is the value the one-cycle look-back sees. The bench changes every input only at falling edges, and it keeps reset high for the first two edges of the run. Fill mode is toggled in long runs and in single-cycle pulses, and the inbound tap values change while they are meant to be ignored. This shows that only the sampled level of fill mode selects the segment source.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  // Default geometry of one channel
  parameter int unsigned DEF_SEG_LEN = 16;
  parameter int unsigned DEF_NUM_SEG = 4;

  // Source for the first stage of a segment
  typedef enum logic {
    SRC_CHAIN = 1'b0,
    SRC_TAP   = 1'b1
  } seg_src_e;

  function automatic seg_src_e src_from_mode(input logic fill);
    return fill ? SRC_TAP : SRC_CHAIN;
  endfunction
endpackage

// File: rtl/tapsr_src_sel.sv
module tapsr_src_sel
  import tapsr_pkg::*;
(
  input  seg_src_e sel,
  input  logic     chain_bit,
  input  logic     tap_bit,
  output logic     seg_in
);
  always_comb begin
    unique case (sel)
      SRC_TAP:   seg_in = tap_bit;
      default:   seg_in = chain_bit;
    endcase
  end
endmodule

// File: rtl/tapsr_lane.sv
module tapsr_lane #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic seg_in,
  output logic head,
  output logic tail
);
  logic [LEN-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[LEN-2:0], seg_in};
  end

  assign head = stage_q[0];
  assign tail = stage_q[LEN-1];
endmodule

// File: rtl/tapsr_chain.sv
module tapsr_chain
  import tapsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = DEF_SEG_LEN,
  parameter int unsigned NUM_SEG = DEF_NUM_SEG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic               fill,
  input  logic [NUM_SEG-2:0] tap_d,
  output logic [NUM_SEG-1:0] tap_q,
  output logic [NUM_SEG-1:0] tap_oe,
  output logic [NUM_SEG-1:0] lane_head,
  output logic [NUM_SEG-1:0] lane_tail
);
  seg_src_e           src_sel;
  logic [NUM_SEG-1:0] seg_in;

  assign src_sel = src_from_mode(fill);

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign seg_in[k] = din;
    end else begin : g_inner
      tapsr_src_sel u_sel (
        .sel       (src_sel),
        .chain_bit (lane_tail[k-1]),
        .tap_bit   (tap_d[k-1]),
        .seg_in    (seg_in[k])
      );
    end

    tapsr_lane #(.LEN(SEG_LEN)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .seg_in (seg_in[k]),
      .head   (lane_head[k]),
      .tail   (lane_tail[k])
    );
  end

  assign tap_q  = lane_tail;
  assign tap_oe = {NUM_SEG{~fill}};
endmodule

// File: rtl/tapsr_dual.sv
module tapsr_dual
  import tapsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = DEF_SEG_LEN,
  parameter int unsigned NUM_SEG = DEF_NUM_SEG
) (
  input  logic               clk_a,
  input  logic               rst_a,
  input  logic               din_a,
  input  logic               fill_a,
  input  logic [NUM_SEG-2:0] tap_d_a,
  output logic [NUM_SEG-1:0] tap_q_a,
  output logic [NUM_SEG-1:0] tap_oe_a,
  input  logic               clk_b,
  input  logic               rst_b,
  input  logic               din_b,
  input  logic               fill_b,
  input  logic [NUM_SEG-2:0] tap_d_b,
  output logic [NUM_SEG-1:0] tap_q_b,
  output logic [NUM_SEG-1:0] tap_oe_b
);
  logic [NUM_SEG-1:0] head_a, tail_a, head_b, tail_b;

  tapsr_chain #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_chan_a (
    .clk (clk_a), .rst (rst_a), .din (din_a), .fill (fill_a),
    .tap_d (tap_d_a), .tap_q (tap_q_a), .tap_oe (tap_oe_a),
    .lane_head (head_a), .lane_tail (tail_a)
  );

  tapsr_chain #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_chan_b (
    .clk (clk_b), .rst (rst_b), .din (din_b), .fill (fill_b),
    .tap_d (tap_d_b), .tap_q (tap_q_b), .tap_oe (tap_oe_b),
    .lane_head (head_b), .lane_tail (tail_b)
  );
endmodule

// File: rtl/tapsr_chk.sv
module tapsr_chk #(
  parameter int unsigned NUM_SEG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               din,
  input logic               fill,
  input logic [NUM_SEG-2:0] tap_d,
  input logic [NUM_SEG-1:0] tap_q,
  input logic [NUM_SEG-1:0] tap_oe,
  input logic [NUM_SEG-1:0] lane_head,
  input logic [NUM_SEG-1:0] lane_tail
);
  // R1: reset empties every segment
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (lane_head == '0 && lane_tail == '0 && tap_q == '0));

  // R2: stage 1 takes the serial input in both modes
  assert_serial_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> lane_head[0] == $past(din));

  // R4: tap drivers follow the inverse of fill mode
  assert_oe_follows_mode_R4: assert property (@(posedge clk) disable iff (rst)
    tap_oe == {NUM_SEG{!fill}});

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_link
    // R3 / R6: ordinary shift links segments and ignores the inbound tap
    assert_chain_link_R3: assert property (@(posedge clk) disable iff (rst)
      !fill |=> lane_head[k] == $past(lane_tail[k-1]));
    // R5: fill mode loads the inbound tap into the next segment
    assert_tap_load_R5: assert property (@(posedge clk) disable iff (rst)
      fill |=> lane_head[k] == $past(tap_d[k-1]));
  end
endmodule

bind tapsr_dual tapsr_chk #(.NUM_SEG(NUM_SEG)) u_chk_a (
  .clk (clk_a), .rst (rst_a), .din (din_a), .fill (fill_a),
  .tap_d (tap_d_a), .tap_q (tap_q_a), .tap_oe (tap_oe_a),
  .lane_head (head_a), .lane_tail (tail_a)
);

bind tapsr_dual tapsr_chk #(.NUM_SEG(NUM_SEG)) u_chk_b (
  .clk (clk_b), .rst (rst_b), .din (din_b), .fill (fill_b),
  .tap_d (tap_d_b), .tap_q (tap_q_b), .tap_oe (tap_oe_b),
  .lane_head (head_b), .lane_tail (tail_b)
);

// File: tb/tapsr_dual_bench.sv
module tapsr_dual_bench;
  localparam int PERIOD = 10;

  logic       clk;
  logic       rst_a, din_a, fill_a, rst_b, din_b, fill_b;
  logic [2:0] tap_d_a, tap_d_b;
  logic [3:0] tap_q_a, tap_oe_a, tap_q_b, tap_oe_b;

  tapsr_dual u_tapsr_dual (
    .clk_a (clk), .rst_a (rst_a), .din_a (din_a), .fill_a (fill_a),
    .tap_d_a (tap_d_a), .tap_q_a (tap_q_a), .tap_oe_a (tap_oe_a),
    .clk_b (clk), .rst_b (rst_b), .din_b (din_b), .fill_b (fill_b),
    .tap_d_b (tap_d_b), .tap_q_b (tap_q_b), .tap_oe_b (tap_oe_b)
  );

  typedef struct {
    logic [3:0] qa, oea, qb, oeb;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic [63:0] ma = '0, mb = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] fill_pat;

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // Reference from the requirements: bit 0 is stage 1
  function automatic logic [63:0] next_state(logic [63:0] m, logic r,
                                             logic d, logic f, logic [2:0] td);
    logic [63:0] n;
    if (r) return '0;
    n = {m[62:0], d};
    if (f) begin
      n[16] = td[0];
      n[32] = td[1];
      n[48] = td[2];
    end
    return n;
  endfunction

  function automatic logic [3:0] taps_of(logic [63:0] m);
    return {m[63], m[47], m[31], m[15]};
  endfunction

  function automatic logic rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(string tag,
                      logic ra, logic da, logic fa, logic [2:0] ta,
                      logic rb, logic db, logic fb, logic [2:0] tb);
    exp_t e;
    @(negedge clk);
    rst_a = ra; din_a = da; fill_a = fa; tap_d_a = ta;
    rst_b = rb; din_b = db; fill_b = fb; tap_d_b = tb;
    ma = next_state(ma, ra, da, fa, ta);
    mb = next_state(mb, rb, db, fb, tb);
    e.qa = taps_of(ma); e.oea = {4{~fa}};
    e.qb = taps_of(mb); e.oeb = {4{~fb}};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: sample a quarter period after each rising edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (tap_q_a !== e.qa || tap_oe_a !== e.oea) begin
        n_fail++;
        $display("FAIL %s chan A: q=%b oe=%b expected q=%b oe=%b",
                 e.tag, tap_q_a, tap_oe_a, e.qa, e.oea);
      end else if (tap_q_b !== e.qb || tap_oe_b !== e.oeb) begin
        n_fail++;
        $display("FAIL %s chan B: q=%b oe=%b expected q=%b oe=%b",
                 e.tag, tap_q_b, tap_oe_b, e.qb, e.oeb);
      end
    end
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b1; din_a = 1'b0; din_b = 1'b0;
    fill_a = 1'b0; fill_b = 1'b0; tap_d_a = '0; tap_d_b = '0;
    // R1: power-up reset
    step("R1", 1, 0, 0, 3'b000, 1, 0, 0, 3'b000);
    step("R1", 1, 1, 0, 3'b111, 1, 1, 0, 3'b111);
    // R3 / R6: plain shift on A with garbage on tap_d; B in fill mode (R9)
    for (int i = 0; i < 72; i++) begin
      logic d;
      d = rnd_bit();
      step((i % 2) ? "R3" : "R6", 0, d, 0, 3'(i * 5),
           0, ~d, (i < 20), 3'(i));
    end
    // R4 / R5 / R7: 16-clock segment fill on A; B shifts (R9)
    for (int i = 0; i < 16; i++) begin
      logic [2:0] t;
      logic d;
      t = {rnd_bit(), rnd_bit(), rnd_bit()};
      d = rnd_bit();
      step(i == 0 ? "R4" : (i < 8 ? "R5" : "R7"), 0, d, 1, t,
           0, rnd_bit(), 0, 3'b101);
    end
    // R8: drain the filled pattern with fill mode low
    for (int i = 0; i < 64; i++)
      step("R8", 0, 0, 0, 3'b111, 0, rnd_bit(), 0, 3'b010);
    // R2: single-cycle fill pulses with a marked serial bit
    for (int i = 0; i < 40; i++)
      step("R2", 0, (i % 9 == 0), (i % 7 == 3), 3'(i * 3),
           0, (i % 4 == 0), (i % 5 == 1), 3'(~i));
    // R1: mid-stream reset on A only; B keeps running (R9)
    step("R1", 1, 1, 0, 3'b000, 0, 1, 0, 3'b000);
    for (int i = 0; i < 20; i++)
      step("R9", 0, 0, 0, 3'b000, 0, rnd_bit(), 1, 3'(i));
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule